// File: doc/BRIEF.md
# Masked-Write GPIO Port

This block is a 32-pin general-purpose I/O port controlled through a small memory-mapped register bus. It holds two 32-bit state registers: the output values the pins drive, and the per-pin direction. Each of these registers is reached as two 16-bit halves at adjacent word addresses. Pins 0 to 15 live in the lower half and pins 16 to 31 in the upper half.

Every write to a half carries its own bit mask. The upper sixteen bits of the write data say which pins to touch, and the lower sixteen bits carry the new values. Software can therefore set, clear or turn around one pin in a single bus cycle, without reading the register first and without racing another agent that owns other pins.

The port also returns the levels of all 32 pins in a single read. These levels pass through a two-flop synchronizer first. A fixed identifier register lets software find out which register layout it is talking to. The bus accepts one request per cycle and answers each one with a response pulse one cycle later.

Top module: `gpio_mwe_port`

## Requirements
- R1: During and after reset, every output-value bit and every direction bit is 0. As a result, `pin_out` and `pin_oe` are all zero and `rsp_valid` is low.
- R2: A write to offset 0x00 or 0x08 uses `req_wdata[31:16]` as per-bit enables for pins 15..0. Each pin whose enable is 1 takes the value of the matching bit of `req_wdata[15:0]`. Every other pin keeps its previous value.
- R3: Offsets 0x04 and 0x0C address pins 31..16 in the same way: enable bit k and value bit k act on pin 16+k. Such a write leaves pins 15..0 unchanged.
- R4: A read of any of the four half offsets returns the 16 stored bits of that half in `rsp_rdata[15:0]`, with `rsp_rdata[31:16]` equal to 0.
- R5: `pin_out` always equals the output-value register (offsets 0x00/0x04). `pin_oe` always equals the direction register (offsets 0x08/0x0C), where a direction bit of 1 makes the pin an output and 0 makes it an input. Both update on the clock edge that accepts the write.
- R6: A read of offset 0x70 returns all 32 pin levels, bit n for pin n. The value returned is `pin_in` as captured two clock edges before the edge that accepts the read.
- R7: A read of offset 0x78 returns 0x01000C2B.
- R8: A read of any other offset, including a non-word-aligned one, returns 0. A write to any offset other than the four half offsets, including 0x70 and 0x78, changes no state.
- R9: `req_ready` is always 1 outside reset. `rsp_valid` is high in the cycle after each accepted request and low otherwise. For a write, `rsp_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data: [31:16] enables, [15:0] values |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Values driven onto the pins |
| pin_oe | output | 32 | Per-pin output enable |

## Verification
The bench drives long random runs of masked writes to all four half offsets, each with random enables and values. A design that ignored the enable mask, or that let the mask of one half reach the other, would corrupt pins that the model leaves alone.

Directed cases cover the following:
- All-zero and all-one masks.
- Writes to read-only and unmapped offsets, which must leave both registers untouched.
- Non-aligned addresses, which must decode to nothing.
- A read issued in the same cycle a pin changes, which must still return the old level. A synchronizer with one stage too few, or one too many, returns the wrong value on either that read or the read that follows it.

// File: rtl/gpio_mwe_pkg.sv
package gpio_mwe_pkg;

    localparam int unsigned PIN_CNT  = 32;
    localparam int unsigned HALF_W   = PIN_CNT / 2;
    localparam int unsigned N_HALVES = 2;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned DATA_W   = 32;

    localparam logic [DATA_W-1:0] ID_VALUE = 32'h01000C2B;

    localparam logic [ADDR_W-1:0] OFS_OUTV  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIRN  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_LEVEL = 8'h70;
    localparam logic [ADDR_W-1:0] OFS_IDENT = 8'h78;
    localparam logic [ADDR_W-1:0] HALF_STEP = 8'h04;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_OUTV,
        TGT_DIRN,
        TGT_LEVEL,
        TGT_IDENT
    } target_e;

    typedef struct packed {
        target_e tgt;
        logic    upper;
    } decode_t;

    typedef struct packed {
        logic [HALF_W-1:0] en;
        logic [HALF_W-1:0] val;
    } wmask_t;

    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a);
        decode_t d;
        logic [ADDR_W-1:0] base;
        base    = a & ~HALF_STEP;
        d.upper = a[2];
        if (base == OFS_OUTV)       d.tgt = TGT_OUTV;
        else if (base == OFS_DIRN)  d.tgt = TGT_DIRN;
        else if (a == OFS_LEVEL)    d.tgt = TGT_LEVEL;
        else if (a == OFS_IDENT)    d.tgt = TGT_IDENT;
        else                        d.tgt = TGT_NONE;
        return d;
    endfunction

    function automatic logic [HALF_W-1:0] merge_half(input logic [HALF_W-1:0] old,
                                                     input wmask_t w);
        return (old & ~w.en) | (w.val & w.en);
    endfunction

endpackage

// File: rtl/gpio_mwe_sync.sv
module gpio_mwe_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_mwe_half_reg.sv
module gpio_mwe_half_reg
    import gpio_mwe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  wmask_t            wr,
    output logic [HALF_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= merge_half(q, wr);
    end
endmodule

// File: rtl/gpio_mwe_bus.sv
module gpio_mwe_bus
    import gpio_mwe_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [PIN_CNT-1:0]  outv_q,
    input  logic [PIN_CNT-1:0]  dirn_q,
    input  logic [PIN_CNT-1:0]  level_q,
    output logic [N_HALVES-1:0] outv_we,
    output logic [N_HALVES-1:0] dirn_we,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata
);
    decode_t          dec;
    logic             fire;
    logic [DATA_W-1:0] rd_mux;

    assign req_ready = ~rst;
    assign fire      = req_valid & req_ready;
    assign dec       = decode_addr(req_addr);

    for (genvar h = 0; h < N_HALVES; h++) begin : g_we
        assign outv_we[h] = fire & req_write & (dec.tgt == TGT_OUTV) & (dec.upper == h[0]);
        assign dirn_we[h] = fire & req_write & (dec.tgt == TGT_DIRN) & (dec.upper == h[0]);
    end

    always_comb begin
        rd_mux = '0;
        unique case (dec.tgt)
            TGT_OUTV:  rd_mux[HALF_W-1:0] = dec.upper ? outv_q[PIN_CNT-1:HALF_W] : outv_q[HALF_W-1:0];
            TGT_DIRN:  rd_mux[HALF_W-1:0] = dec.upper ? dirn_q[PIN_CNT-1:HALF_W] : dirn_q[HALF_W-1:0];
            TGT_LEVEL: rd_mux = level_q;
            TGT_IDENT: rd_mux = ID_VALUE;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= fire;
            rsp_rdata <= (fire & ~req_write) ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/gpio_mwe_port.sv
module gpio_mwe_port
    import gpio_mwe_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    input  logic [PIN_CNT-1:0] pin_in,
    output logic [PIN_CNT-1:0] pin_out,
    output logic [PIN_CNT-1:0] pin_oe
);
    logic [N_HALVES-1:0] outv_we;
    logic [N_HALVES-1:0] dirn_we;
    logic [PIN_CNT-1:0]  level_q;
    wmask_t              wr;

    assign wr = wmask_t'(req_wdata);

    gpio_mwe_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (level_q)
    );

    for (genvar h = 0; h < N_HALVES; h++) begin : g_half
        gpio_mwe_half_reg u_outv (
            .clk   (clk),
            .rst   (rst),
            .wr_en (outv_we[h]),
            .wr    (wr),
            .q     (pin_out[h*HALF_W +: HALF_W])
        );
        gpio_mwe_half_reg u_dirn (
            .clk   (clk),
            .rst   (rst),
            .wr_en (dirn_we[h]),
            .wr    (wr),
            .q     (pin_oe[h*HALF_W +: HALF_W])
        );
    end

    gpio_mwe_bus u_bus (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .outv_q    (pin_out),
        .dirn_q    (pin_oe),
        .level_q   (level_q),
        .outv_we   (outv_we),
        .dirn_we   (dirn_we),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );
endmodule

// File: rtl/gpio_mwe_port_chk.sv
module gpio_mwe_port_chk
    import gpio_mwe_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic               req_write,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [DATA_W-1:0]  req_wdata,
    input logic               rsp_valid,
    input logic [DATA_W-1:0]  rsp_rdata,
    input logic [PIN_CNT-1:0] pin_in,
    input logic [PIN_CNT-1:0] pin_out,
    input logic [PIN_CNT-1:0] pin_oe
);
    logic acc, acc_wr, acc_rd;
    logic any_outv_wr, any_dirn_wr;
    assign acc         = req_valid && req_ready;
    assign acc_wr      = acc && req_write;
    assign acc_rd      = acc && !req_write;
    assign any_outv_wr = acc_wr && ((req_addr == 8'h00) || (req_addr == 8'h04));
    assign any_dirn_wr = acc_wr && ((req_addr == 8'h08) || (req_addr == 8'h0C));

    AST_RESET_CLEAR: assert property (@(posedge clk) $fell(rst) |-> (pin_out == '0 && pin_oe == '0 && !rsp_valid)); // R1
    AST_LO_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && req_addr == 8'h00) |=> ((pin_out[15:0] & ~$past(req_wdata[31:16])) == ($past(pin_out[15:0]) & ~$past(req_wdata[31:16])))); // R2
    AST_HI_SPARES_LO: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && req_addr == 8'h04) |=> $stable(pin_out[15:0])); // R3
    AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && req_addr[7:4] == 4'h0 && req_addr[1:0] == 2'b00) |=> (rsp_rdata[31:16] == 16'h0)); // R4
    AST_OUTV_HOLD: assert property (@(posedge clk) disable iff (rst)
        !any_outv_wr |=> $stable(pin_out)); // R5
    AST_DIRN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !any_dirn_wr |=> $stable(pin_oe)); // R8
    AST_IDENT_VALUE: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && req_addr == 8'h78) |=> (rsp_rdata == 32'h01000C2B)); // R7
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        acc |=> rsp_valid); // R9
    AST_RSP_ONLY_AFTER: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !rsp_valid); // R9
    AST_READY_HIGH: assert property (@(posedge clk) disable iff (rst) req_ready); // R9
endmodule

bind gpio_mwe_port gpio_mwe_port_chk u_chk (.*);

// File: tb/gpio_mwe_port_test.sv
module gpio_mwe_port_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [31:0] pin_in, pin_out, pin_oe;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] m_outv, m_dirn;

    always #5 clk = ~clk;

    gpio_mwe_port uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] apply_wr(input logic [31:0] old, input logic hi, input logic [31:0] wd);
        logic [15:0] en = wd[31:16];
        logic [15:0] v  = wd[15:0];
        logic [31:0] r  = old;
        if (hi) r[31:16] = (old[31:16] & ~en) | (v & en);
        else    r[15:0]  = (old[15:0]  & ~en) | (v & en);
        return r;
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00: return {16'h0, m_outv[15:0]};
            8'h04: return {16'h0, m_outv[31:16]};
            8'h08: return {16'h0, m_dirn[15:0]};
            8'h0C: return {16'h0, m_dirn[31:16]};
            8'h78: return 32'h01000C2B;
            default: return 32'h0;
        endcase
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = wd;
        if (a == 8'h00 || a == 8'h04) m_outv = apply_wr(m_outv, a[2], wd);
        if (a == 8'h08 || a == 8'h0C) m_dirn = apply_wr(m_dirn, a[2], wd);
        @(negedge clk);
        req_valid = 0;
        check(rsp_valid === 1'b1, "R9 write rsp_valid", {31'h0, rsp_valid}, 32'h1);
        check(rsp_rdata === 32'h0, "R9 write rdata", rsp_rdata, 32'h0);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_wdata = $urandom;
        @(negedge clk);
        req_valid = 0;
        check(rsp_valid === 1'b1, "R9 read rsp_valid", {31'h0, rsp_valid}, 32'h1);
        rd = rsp_rdata;
    endtask

    task automatic check_pins(input string req);
        check(pin_out === m_outv, {req, " pin_out"}, pin_out, m_outv);
        check(pin_oe === m_dirn, {req, " pin_oe"}, pin_oe, m_dirn);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [7:0] half_addrs [4] = '{8'h00, 8'h04, 8'h08, 8'h0C};
        void'($urandom(32'd1234));
        rst = 1; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; pin_in = 32'h0;
        m_outv = 0; m_dirn = 0;
        repeat (3) @(negedge clk);
        check(pin_out === 0 && pin_oe === 0, "R1 in reset", pin_out | pin_oe, 0);
        rst = 0;
        @(negedge clk);
        check_pins("R1 after reset");
        check(rsp_valid === 1'b0, "R1 rsp idle", {31'h0, rsp_valid}, 0);
        check(req_ready === 1'b1, "R9 ready", {31'h0, req_ready}, 1);

        // R2 single-pin set with mask
        bus_write(8'h00, 32'h0004_FFFF); check_pins("R2 single bit");
        bus_write(8'h00, 32'h0000_FFFF); check_pins("R2 zero mask");
        bus_write(8'h00, 32'hFFFF_A5A5); check_pins("R2 full mask");
        // R3 upper halves
        bus_write(8'h04, 32'h8001_FFFF); check_pins("R3 upper data");
        bus_write(8'h0C, 32'hFFFF_00F0); check_pins("R3 upper dir");
        bus_write(8'h08, 32'h0101_0100); check_pins("R5 dir lo");
        for (int i = 0; i < 4; i++) begin
            bus_read(half_addrs[i], rd);
            check(rd === model_read(half_addrs[i]), "R4 half readback", rd, model_read(half_addrs[i]));
        end

        // R8 writes to read-only and unmapped offsets
        bus_write(8'h78, 32'hFFFF_FFFF); check_pins("R8 write ident");
        bus_write(8'h70, 32'hFFFF_FFFF); check_pins("R8 write level");
        bus_write(8'h10, 32'hFFFF_FFFF); check_pins("R8 write unmapped");
        bus_write(8'h01, 32'hFFFF_FFFF); check_pins("R8 write unaligned");
        bus_write(8'h0E, 32'hFFFF_FFFF); check_pins("R8 write unaligned hi");
        bus_read(8'h10, rd); check(rd === 0, "R8 read unmapped", rd, 0);
        bus_read(8'h74, rd); check(rd === 0, "R8 read 0x74", rd, 0);
        bus_read(8'h02, rd); check(rd === 0, "R8 read unaligned", rd, 0);
        bus_read(8'hFC, rd); check(rd === 0, "R8 read top", rd, 0);
        bus_read(8'h78, rd); check(rd === 32'h01000C2B, "R7 ident", rd, 32'h01000C2B);

        // R6 pin levels and synchronizer latency
        pin_in = 32'hDEAD_BEEF;
        repeat (4) @(negedge clk);
        bus_read(8'h70, rd); check(rd === 32'hDEAD_BEEF, "R6 settled level", rd, 32'hDEAD_BEEF);
        pin_in = 32'h1234_5678;
        bus_read(8'h70, rd); check(rd === 32'hDEAD_BEEF, "R6 two-edge latency old", rd, 32'hDEAD_BEEF);
        bus_read(8'h70, rd); check(rd === 32'h1234_5678, "R6 two-edge latency new", rd, 32'h1234_5678);

        // idle cycle: no response
        @(negedge clk);
        check(rsp_valid === 1'b0, "R9 no request no rsp", {31'h0, rsp_valid}, 0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [7:0] a;
            a = half_addrs[$urandom_range(0, 3)];
            if ($urandom_range(0, 2) != 0) begin
                bus_write(a, $urandom);
                check_pins(a[3] ? "R5 random dir" : (a[2] ? "R3 random" : "R2 random"));
            end else begin
                bus_read(a, rd);
                check(rd === model_read(a), "R4 random readback", rd, model_read(a));
            end
            if (n % 50 == 0) begin
                pin_in = $urandom;
                repeat (3) @(negedge clk);
                bus_read(8'h70, rd); check(rd === pin_in, "R6 random level", rd, pin_in);
            end
        end

        // reset mid-run clears state
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0; m_outv = 0; m_dirn = 0;
        check_pins("R1 re-reset");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule